// File: doc/BRIEF.md
# Block-Gated HDLC Receive Byte Pool

This block sits between an HDLC receive deframer and a host register interface. Each received byte comes with start-of-frame and end-of-frame markers. The block stores the bytes in a 32-byte circular pool and cuts each frame into blocks. A block closes when it reaches the programmed threshold size, or when the frame ends.

The host sees one closed block at a time, through one of two interrupts:
- The block-ready interrupt means a full threshold-sized block is waiting and the frame is still open.
- The end-of-message interrupt means the frame has closed. The 12-bit byte count of the whole frame is then shown in two byte-wide registers.

The host reads the block as bytes or as 16-bit words. It then issues a release command. The release frees the block's storage and lets the next block be presented. If bytes arrive while the pool is full and unreleased, they are dropped. A sticky overflow flag is set, and the frame is marked aborted when its end-of-message interrupt is presented.

Top module: `rx_msg_pool`

## Requirements
- R1: After reset both interrupts are low, the byte count reads 0, the abort and overflow flags are low, and `rd_data` is 0.
- R2: `thr_sel` selects the block size: 2'b00 = 32, 2'b01 = 16, 2'b10 = 4, 2'b11 = 2 bytes. When that many bytes of an open frame have been accepted and the last of them is not marked end-of-frame, a block closes and `irq_block` is raised for it.
- R3: A byte marked `in_eof` closes the frame's last block, and `irq_end` is raised for it. That block holds the bytes accepted since the previous block boundary: ((count−1) mod size)+1 bytes for a count of 1 or more.
- R4: When `irq_end` is raised, `cnt_lo` shows bits 7:0 and `cnt_hi` shows bits 11:8, in its low nibble with the upper nibble 0, of the number of accepted bytes of that frame. The registers hold their value until the next end-of-message block is presented.
- R5: In 8-bit mode (`bus16`=0), each `rd_en` returns the next byte of the presented block in arrival order on `rd_data[7:0]`, with `rd_data[15:8]` at 0. `rd_data` shows the current item before the `rd_en` pulse that consumes it.
- R6: In 16-bit mode (`bus16`=1), each read returns two bytes: the earlier received in bits 7:0, the later in bits 15:8. For an odd tail, bits 15:8 of the last word read 0.
- R7: Once the whole presented block has been read, `rd_data` is 0 and further reads do not move the read position.
- R8: At most one interrupt is pending at a time. It stays asserted, with an unchanged count, until `rmc` is pulsed. Later blocks, including blocks of later frames, are presented in arrival order only after that release.
- R9: A `rmc` pulse with no interrupt pending has no effect on stored data or on the next block presented.
- R10: A byte arriving while 32 bytes are stored unreleased is dropped. `ovf_flag` is set and stays set until reset. That frame's end-of-message block raises `irq_end` with `msg_abort`=1, and its count covers only the accepted bytes.
- R11: Storage freed by a release is reused circularly, so frames longer than the pool pass intact when the host releases each block in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus16 | input | 1 | 1 = 16-bit host reads, 0 = 8-bit host reads |
| thr_sel | input | 2 | Block size select (00=32, 01=16, 10=4, 11=2) |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte, bit 0 earliest on the line |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| rd_en | input | 1 | Host read strobe, consumes the current item |
| rmc | input | 1 | Release command for the presented block |
| rd_data | output | 16 | Current read item |
| irq_block | output | 1 | Full threshold block pending, frame still open |
| irq_end | output | 1 | End-of-message block pending |
| cnt_lo | output | 8 | Frame byte count bits 7:0 |
| cnt_hi | output | 8 | Frame byte count bits 11:8 in bits 3:0 |
| msg_abort | output | 1 | Last presented frame lost bytes |
| ovf_flag | output | 1 | Sticky overflow |

## Verification
Frame lengths from 1 to 70 bytes are swept over all four block sizes in both read widths. Lengths that fall just below, at and just above a multiple of the block size show whether the block boundaries and the end-of-message remainder are placed correctly. Odd lengths in word mode expose the handling of the upper byte.

A 300-byte frame checks the high count byte. Queued back-to-back frames without service show whether the pending interrupt is held and the blocks are ordered. Flooding a full pool shows the drop, the sticky flag and the abort marking, and that the next frame comes through clean. A stray release with nothing pending must leave the pool untouched.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int unsigned LEN_W = 7;
  localparam int unsigned CNT_W = 12;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             last;
    logic             abort;
    logic [CNT_W-1:0] fcnt;
  } blk_desc_t;

  function automatic logic [LEN_W-1:0] thr_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return LEN_W'(32);
      2'b01:   return LEN_W'(16);
      2'b10:   return LEN_W'(4);
      default: return LEN_W'(2);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + CNT_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] rd_step(input logic [LEN_W-1:0] off,
                                               input logic [LEN_W-1:0] len,
                                               input logic wide);
    if (off >= len) return '0;
    if (wide && (off + LEN_W'(1) < len)) return LEN_W'(2);
    return LEN_W'(1);
  endfunction
endpackage

// File: rtl/rxp_store.sv
module rxp_store
  import rxp_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rel_en,
  input  logic [LEN_W-1:0] rel_len,
  input  logic [LEN_W-1:0] rd_off,
  output logic [7:0]       rd_lo,
  output logic [7:0]       rd_hi,
  output logic             full
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, head, a0, a1;
  logic [AW:0]   occ_q;
  logic [AW:0]   rel_amt;

  assign full    = (occ_q == (AW+1)'(DEPTH));
  assign rel_amt = rel_en ? (AW+1)'(rel_len) : '0;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      head  <= '0;
      occ_q <= '0;
    end else begin
      if (wr_en)  wptr <= wptr + AW'(1);
      if (rel_en) head <= head + rel_len[AW-1:0];
      occ_q <= occ_q + (AW+1)'(wr_en) - rel_amt;
    end
  end

  always_comb begin
    a0    = head + rd_off[AW-1:0];
    a1    = a0 + AW'(1);
    rd_lo = mem[a0];
    rd_hi = mem[a1];
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= (AW+1)'(DEPTH));
  // R10
  wr_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  // R11
  rel_within_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> ((AW+1)'(rel_len) <= occ_q));
endmodule

// File: rtl/rxp_descq.sv
module rxp_descq
  import rxp_pkg::*;
#(
  parameter int unsigned QDEPTH = 32,
  localparam int unsigned QAW = $clog2(QDEPTH)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  blk_desc_t din,
  input  logic      pop,
  output blk_desc_t dout,
  output logic      empty,
  output logic      qfull
);
  blk_desc_t      slots [QDEPTH];
  logic [QAW-1:0] wp, rp;
  logic [QAW:0]   cnt;

  assign empty = (cnt == '0);
  assign qfull = (cnt == (QAW+1)'(QDEPTH));
  assign dout  = slots[rp];

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + QAW'(1);
      if (pop)  rp <= rp + QAW'(1);
      cnt <= cnt + (QAW+1)'(push) - (QAW+1)'(pop);
    end
  end

  // R8
  q_push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !qfull);
  // R8
  q_pop_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rxp_segmenter.sv
module rxp_segmenter
  import rxp_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] thr_sel,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       full,
  input  logic       qfull,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       push,
  output blk_desc_t  desc,
  output logic       ovf_evt
);
  logic [LEN_W-1:0] cur_len, base_len, n_len, thr;
  logic [CNT_W-1:0] fcnt, base_cnt, n_cnt;
  logic             abort_q, base_ab, n_ab;
  logic             acc, drop, push_end, push_thr, push_req, q_drop;

  always_comb begin
    thr      = thr_bytes(thr_sel);
    acc      = in_valid && !full;
    drop     = in_valid && full;
    base_len = in_sof ? '0 : cur_len;
    base_cnt = in_sof ? '0 : fcnt;
    base_ab  = in_sof ? 1'b0 : abort_q;
    n_len    = acc ? base_len + LEN_W'(1) : base_len;
    n_cnt    = acc ? sat_inc(base_cnt) : base_cnt;
    push_end = in_valid && in_eof;
    push_thr = acc && !in_eof && (n_len >= thr);
    push_req = push_end || push_thr;
    q_drop   = push_req && qfull;
    push     = push_req && !qfull;
    n_ab     = base_ab || drop || q_drop;
    desc     = '{len: n_len, last: push_end, abort: n_ab, fcnt: n_cnt};
    wr_en    = acc;
    wr_data  = in_data;
    ovf_evt  = drop || q_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_len <= '0;
      fcnt    <= '0;
      abort_q <= 1'b0;
    end else if (in_valid) begin
      cur_len <= push_req ? '0 : n_len;
      fcnt    <= push_end ? '0 : n_cnt;
      abort_q <= push_end ? 1'b0 : n_ab;
    end
  end

  // R2
  blk_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (desc.len <= LEN_W'(DEPTH)));
  // R3
  blk_len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !desc.abort) |-> (desc.len != '0));
endmodule

// File: rtl/rx_msg_pool.sv
module rx_msg_pool
  import rxp_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus16,
  input  logic [1:0]  thr_sel,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        rd_en,
  input  logic        rmc,
  output logic [15:0] rd_data,
  output logic        irq_block,
  output logic        irq_end,
  output logic [7:0]  cnt_lo,
  output logic [7:0]  cnt_hi,
  output logic        msg_abort,
  output logic        ovf_flag
);
  logic             wr_en, full, push, qfull, q_empty, ovf_evt;
  logic [7:0]       wr_data, rd_lo, rd_hi;
  blk_desc_t        seg_desc, q_head, pres;
  logic             pend_blk, pend_end, pending, rel, pop;
  logic [LEN_W-1:0] rd_off;
  logic [CNT_W-1:0] cnt_q;
  logic             abort_q, ovf_q;
  logic             lo_ok, hi_ok;

  rxp_segmenter #(.DEPTH(DEPTH)) u_seg (
    .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel), .in_valid(in_valid),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .full(full),
    .qfull(qfull), .wr_en(wr_en), .wr_data(wr_data), .push(push),
    .desc(seg_desc), .ovf_evt(ovf_evt)
  );

  rxp_descq #(.QDEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .din(seg_desc), .pop(pop),
    .dout(q_head), .empty(q_empty), .qfull(qfull)
  );

  rxp_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rel_en(rel), .rel_len(pres.len), .rd_off(rd_off),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .full(full)
  );

  assign pending = pend_blk || pend_end;
  assign rel     = rmc && pending;
  assign pop     = !pending && !q_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_blk <= 1'b0;
      pend_end <= 1'b0;
      pres     <= '0;
      rd_off   <= '0;
      cnt_q    <= '0;
      abort_q  <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (ovf_evt) ovf_q <= 1'b1;
      if (rel) begin
        pend_blk <= 1'b0;
        pend_end <= 1'b0;
        pres.len <= '0;
        rd_off   <= '0;
      end else if (pop) begin
        pres     <= q_head;
        pend_blk <= !q_head.last;
        pend_end <= q_head.last;
        rd_off   <= '0;
        if (q_head.last) begin
          cnt_q   <= q_head.fcnt;
          abort_q <= q_head.abort;
        end
      end else if (rd_en && pending) begin
        rd_off <= rd_off + rd_step(rd_off, pres.len, bus16);
      end
    end
  end

  always_comb begin
    lo_ok   = pending && (rd_off < pres.len);
    hi_ok   = lo_ok && bus16 && (rd_off + LEN_W'(1) < pres.len);
    rd_data = {hi_ok ? rd_hi : 8'h00, lo_ok ? rd_lo : 8'h00};
  end

  assign irq_block = pend_blk;
  assign irq_end   = pend_end;
  assign cnt_lo    = cnt_q[7:0];
  assign cnt_hi    = {{(16-CNT_W){1'b0}}, cnt_q[CNT_W-1:8]};
  assign msg_abort = abort_q;
  assign ovf_flag  = ovf_q;

  // R8
  one_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_block, irq_end}));
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !rmc) |=> ($stable({irq_block, irq_end}) && $stable(cnt_q)));
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_q);
  // R7
  rd_off_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (rd_off <= pres.len));
  // R9
  idle_rmc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rmc && !pending && q_empty) |=> !pending);
endmodule

// File: tb/test_rx_msg_pool.sv
`timescale 1ns/1ps
module test_rx_msg_pool;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus16 = 1'b0;
  logic [1:0]  thr_sel = 2'b00;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        rd_en = 1'b0, rmc = 1'b0;
  logic [15:0] rd_data;
  logic        irq_block, irq_end, msg_abort, ovf_flag;
  logic [7:0]  cnt_lo, cnt_hi;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  int         flen_q[$];

  always #10 clk = ~clk;

  rx_msg_pool i_rx_msg_pool (
    .clk(clk), .rst_n(rst_n), .bus16(bus16), .thr_sel(thr_sel),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .rd_en(rd_en), .rmc(rmc), .rd_data(rd_data), .irq_block(irq_block),
    .irq_end(irq_end), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .msg_abort(msg_abort), .ovf_flag(ovf_flag)
  );

  function automatic int blk_size(input logic [1:0] s);
    return (s == 2'b00) ? 32 : (s == 2'b01) ? 16 : (s == 2'b10) ? 4 : 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic read_item(output logic [15:0] v);
    v = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic release_blk();
    rmc = 1'b1;
    @(negedge clk);
    rmc = 1'b0;
  endtask

  // Read n bytes of the presented block and compare with the model.
  task automatic read_block(input int n, input string req);
    logic [15:0] v;
    logic [7:0]  elo, ehi;
    int step;
    step = bus16 ? 2 : 1;
    for (int i = 0; i < n; i += step) begin
      read_item(v);
      elo = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
      ehi = 8'h00;
      if (bus16 && (i + 1 < n)) ehi = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
      check(v == {ehi, elo}, req, v, {ehi, elo});
    end
    // R7: past the end of the block reads give 0
    read_item(v);
    check(v == 16'h0000, "R7", v, 0);
  endtask

  task automatic service();
    int t, c, rem;
    t = blk_size(thr_sel);
    if (irq_block) begin
      read_block(t, bus16 ? "R6 block" : "R5 block");
      release_blk();
    end else if (irq_end) begin
      c = {cnt_hi[3:0], cnt_lo};
      t = (flen_q.size() > 0) ? flen_q.pop_front() : -1;
      check(c == t, "R4 count", c, t);
      check(cnt_hi[7:4] == 4'h0, "R4 hi nibble", cnt_hi, 0);
      check(msg_abort == 1'b0, "R10 no abort", msg_abort, 0);
      rem = (c == 0) ? 0 : ((c - 1) % blk_size(thr_sel)) + 1;
      read_block(rem, bus16 ? "R6 tail R3" : "R5 tail R3");
      release_blk();
    end
  endtask

  task automatic drain();
    int k;
    k = 0;
    while (k < 4) begin
      @(negedge clk);
      if (irq_block || irq_end) begin
        service();
        k = 0;
      end else k++;
    end
  endtask

  task automatic send_frame(input int len, input int seed, input bit serve);
    logic [7:0] d;
    for (int i = 0; i < len; i++) begin
      d = 8'((seed * 37 + i * 13 + (i >> 3)) & 8'hff);
      exp_q.push_back(d);
      if (i == len - 1) flen_q.push_back(len);
      send(d, i == 0, i == len - 1);
      if (serve) drain();
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lens[13] = '{1, 2, 3, 4, 5, 7, 16, 17, 31, 32, 33, 50, 70};
    logic [15:0] v;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(irq_block == 1'b0 && irq_end == 1'b0, "R1 irq", {irq_block, irq_end}, 0);
    check({cnt_hi, cnt_lo} == 16'h0, "R1 count", {cnt_hi, cnt_lo}, 0);
    check(ovf_flag == 1'b0 && msg_abort == 1'b0, "R1 flags", {ovf_flag, msg_abort}, 0);
    check(rd_data == 16'h0, "R1 rd_data", rd_data, 0);

    // R2 R3 R5 R6 R11: sweep sizes, widths and lengths
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 2; b++) begin
        thr_sel = 2'(s);
        bus16 = b[0];
        foreach (lens[i]) send_frame(lens[i], s * 8 + b * 4 + i, 1'b1);
        check(exp_q.size() == 0, "R2 R3 all bytes delivered", exp_q.size(), 0);
      end
    end

    // R4: count above 255
    thr_sel = 2'b11; bus16 = 1'b1;
    send_frame(300, 99, 1'b1);
    check(exp_q.size() == 0, "R4 long frame", exp_q.size(), 0);

    // R9: release with nothing pending
    thr_sel = 2'b11; bus16 = 1'b0;
    release_blk();
    repeat (3) @(negedge clk);
    check(!irq_block && !irq_end, "R9 idle release", {irq_block, irq_end}, 0);
    send_frame(2, 7, 1'b1);
    check(exp_q.size() == 0, "R9 data intact", exp_q.size(), 0);

    // R8: two queued frames, no service until later
    thr_sel = 2'b11; bus16 = 1'b0;
    send_frame(3, 41, 1'b0);
    send_frame(2, 42, 1'b0);
    repeat (6) @(negedge clk);
    check(irq_block == 1'b1 && irq_end == 1'b0, "R8 first block held", {irq_block, irq_end}, 2);
    drain();
    check(exp_q.size() == 0 && flen_q.size() == 0, "R8 order", exp_q.size(), 0);

    // R10: overflow with threshold 32
    thr_sel = 2'b00; bus16 = 1'b0;
    for (int i = 0; i < 35; i++) begin
      if (i < 32) exp_q.push_back(8'(i + 100));
      send(8'(i + 100), i == 0, i == 34);
    end
    repeat (3) @(negedge clk);
    check(ovf_flag == 1'b1, "R10 ovf set", ovf_flag, 1);
    check(irq_block == 1'b1, "R10 full block", irq_block, 1);
    read_block(32, "R10 kept bytes");
    release_blk();
    repeat (3) @(negedge clk);
    check(irq_end == 1'b1, "R10 end irq", irq_end, 1);
    check(msg_abort == 1'b1, "R10 abort", msg_abort, 1);
    c = {cnt_hi[3:0], cnt_lo};
    check(c == 32, "R10 count", c, 32);
    read_item(v);
    check(v == 16'h0, "R10 empty tail R7", v, 0);
    release_blk();
    send_frame(3, 5, 1'b1);
    check(ovf_flag == 1'b1, "R10 sticky", ovf_flag, 1);
    check(msg_abort == 1'b0 && exp_q.size() == 0, "R10 clean next frame", msg_abort, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule